// File: doc/BRIEF.md
# USB Host Frame Timer

This block paces a legacy USB host controller in fixed frames of roughly one millisecond and holds the small register set that governs that pacing. It counts bit-clock cycles; once per frame it raises a one-cycle start-of-frame pulse and shows the current frame number. In the same cycle it raises a fetch strobe with the memory address of the frame list slot that belongs to that frame. Descriptor fetching, bus signalling, ports and interrupt routing live elsewhere.

Software reaches the block through a 16-bit register port (command, status, frame number, frame length trim) and a separate 32-bit port for the frame list base address. The frame length is a fixed base of 11936 cycles plus a 7-bit trim value, so software can nudge the frame period to track an external reference. The timer runs only while the run bit is set. When the run bit is cleared, the frame in progress completes and the block then reports itself halted.

Top module: `usbh_frame_timer`

## Requirements
- R1: After reset the command register reads 0x0000, the status register reads 0x0020 (only the halted bit, bit 5, set), the frame number reads 0, the trim register reads 0x0040, the base address reads 0, and no start-of-frame pulse occurs.
- R2: A running frame lasts FRAME_BASE (default 11936) plus the trim value in bit-clock cycles, measured between consecutive start-of-frame pulses; the default trim gives 12000.
- R3: The trim register (io address 3) keeps its value in bits 6:0; bits 15:7 read as zero.
- R4: The start-of-frame pulse is one cycle wide, occurs only while running, and the first one comes one cycle after the clock edge that writes the run bit (command bit 0) to 1; the fetch strobe coincides with it.
- R5: The frame number (io address 2, bits 10:0, bits 15:11 read zero) increments by one at the end of every frame and wraps from 2047 to 0.
- R6: During a start-of-frame pulse the entry address equals base bits 31:12, then frame number bits 9:0, then two zero bits.
- R7: The base address port stores bits 31:12; bits 11:0 always read as zero.
- R8: Clearing the run bit lets the current frame finish; the halted bit (status bit 5) then sets exactly one frame length after that frame's pulse, and no further pulse follows. Setting the run bit while halted clears the halted bit on the next cycle.
- R9: A write to the frame number takes effect while halted and is ignored while running.
- R10: Status bits 4:0 (USB interrupt, error interrupt, resume, host system error, process error, from bit 0 upward) are set by the event input and cleared by writing 1 to the bit at io address 1; the halted bit ignores such writes.
- R11: The command register (io address 0) stores bits 7:0 and reads them back; bits 15:8 read as zero.
- R12: Writing command bit 1 (controller reset) makes that bit read 1 for one cycle. After that cycle every register is back at its R1 value and the timer is halted at once, without waiting for the frame to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 3 | Register select: 0 command, 1 status, 2 frame number, 3 trim |
| io_we | input | 1 | Write strobe for the 16-bit port |
| io_wdata | input | 16 | Write data for the 16-bit port |
| io_rdata | output | 16 | Read data of the selected register |
| base_we | input | 1 | Write strobe for the base address |
| base_wdata | input | 32 | Base address write data |
| base_rdata | output | 32 | Base address read data |
| sts_evt | input | 5 | Event pulses that set status bits 4:0 |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| frame_num | output | 11 | Current frame number |
| fl_entry_addr | output | 32 | Address of the current frame list slot |
| fl_fetch | output | 1 | Fetch strobe for the frame list slot |

## Verification
The timer runs with three trim settings: the default, zero and the maximum 0x7F. The measured pulse spacing of 12000, 11936 and 12063 cycles tells a correct base-plus-trim sum apart from an off-by-one or a fixed length. Numbering starts at 2046 so that the run crosses both the 10-bit slot index wrap and the 11-bit counter wrap, which checks the address and the frame number separately. Stopping in mid-frame and issuing a controller reset while running tell the graceful halt at frame end apart from the immediate one.

// File: rtl/usbh_ft_pkg.sv
package usbh_ft_pkg;

    localparam int IO_AW       = 3;
    localparam int IO_DW       = 16;
    localparam int ADDR_W      = 32;
    localparam int ALIGN_W     = 12;
    localparam int BASE_HI_W   = ADDR_W - ALIGN_W;
    localparam int FIDX_W      = 11;
    localparam int SLOT_W      = 10;
    localparam int SOFT_W      = 7;
    localparam int EVT_W       = 5;
    localparam int CMD_W       = 8;
    localparam logic [SOFT_W-1:0] SOFT_DEFAULT = 7'h40;

    typedef enum logic [IO_AW-1:0] {
        REG_CMD    = 3'd0,
        REG_STS    = 3'd1,
        REG_FRNUM  = 3'd2,
        REG_SOFMOD = 3'd3
    } reg_sel_e;

    // command bits, bit 7 down to bit 0
    typedef struct packed {
        logic max_pkt;
        logic cfg_flag;
        logic sw_debug;
        logic force_resume;
        logic global_suspend;
        logic global_reset;
        logic hc_reset;
        logic run;
    } cmd_t;

    // sticky status bits, bit 4 down to bit 0
    typedef struct packed {
        logic proc_err;
        logic host_err;
        logic resume;
        logic err_int;
        logic usb_int;
    } sts_ev_t;

    typedef enum logic {
        TM_HALT = 1'b0,
        TM_RUN  = 1'b1
    } tm_state_e;

    function automatic logic [ADDR_W-1:0] slot_addr(
        input logic [BASE_HI_W-1:0] base_hi,
        input logic [FIDX_W-1:0]    idx
    );
        return {base_hi, idx[SLOT_W-1:0], 2'b00};
    endfunction

endpackage

// File: rtl/usbh_ft_regs.sv
module usbh_ft_regs
    import usbh_ft_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IO_AW-1:0]      io_addr,
    input  logic                  io_we,
    input  logic [IO_DW-1:0]      io_wdata,
    output logic [IO_DW-1:0]      io_rdata,
    input  logic                  base_we,
    input  logic [ADDR_W-1:0]     base_wdata,
    input  logic [EVT_W-1:0]      sts_evt,
    input  logic                  halted,
    input  logic [FIDX_W-1:0]     frame_idx,
    output cmd_t                  cmd,
    output logic [SOFT_W-1:0]     sof_timing,
    output logic [BASE_HI_W-1:0]  base_hi,
    output logic                  idx_we
);

    cmd_t                 cmd_q;
    sts_ev_t              sts_q;
    logic [SOFT_W-1:0]    soft_q;
    logic [BASE_HI_W-1:0] base_q;
    logic                 wr_cmd, wr_sts, wr_soft;
    logic [EVT_W-1:0]     clr_mask;
    logic                 unused_bits;

    assign wr_cmd   = io_we && (io_addr == REG_CMD);
    assign wr_sts   = io_we && (io_addr == REG_STS);
    assign wr_soft  = io_we && (io_addr == REG_SOFMOD);
    assign idx_we   = io_we && (io_addr == REG_FRNUM);
    assign clr_mask = wr_sts ? io_wdata[EVT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst || cmd_q.hc_reset) begin
            cmd_q  <= '0;
            sts_q  <= '0;
            soft_q <= SOFT_DEFAULT;
            base_q <= '0;
        end else begin
            if (wr_cmd)
                cmd_q <= cmd_t'(io_wdata[CMD_W-1:0]);
            if (wr_soft)
                soft_q <= io_wdata[SOFT_W-1:0];
            if (base_we)
                base_q <= base_wdata[ADDR_W-1:ALIGN_W];
            // an event in the same cycle as a clear wins
            sts_q <= sts_ev_t'((sts_q & ~clr_mask) | sts_evt);
        end
    end

    always_comb begin
        io_rdata = '0;
        case (io_addr)
            REG_CMD:    io_rdata = {{(IO_DW-CMD_W){1'b0}}, cmd_q};
            REG_STS:    io_rdata = {{(IO_DW-EVT_W-1){1'b0}}, halted, sts_q};
            REG_FRNUM:  io_rdata = {{(IO_DW-FIDX_W){1'b0}}, frame_idx};
            REG_SOFMOD: io_rdata = {{(IO_DW-SOFT_W){1'b0}}, soft_q};
            default:    io_rdata = '0;
        endcase
    end

    assign cmd         = cmd_q;
    assign sof_timing  = soft_q;
    assign base_hi     = base_q;
    assign unused_bits = ^{io_wdata[IO_DW-1:CMD_W], base_wdata[ALIGN_W-1:0]};

endmodule

// File: rtl/usbh_ft_timer.sv
module usbh_ft_timer
    import usbh_ft_pkg::*;
#(
    parameter int FRAME_BASE = 11936
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               run_req,
    input  logic [SOFT_W-1:0]  sof_timing,
    input  logic               idx_we,
    input  logic [FIDX_W-1:0]  idx_wdata,
    output logic               running,
    output logic               sof,
    output logic [FIDX_W-1:0]  frame_idx
);

    localparam int LEN_MAX = FRAME_BASE + (1 << SOFT_W) - 1;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    tm_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   last_cnt;
    logic [FIDX_W-1:0]  idx_q;
    logic               frame_end;

    assign last_cnt  = CNT_W'(FRAME_BASE - 1) + CNT_W'(sof_timing);
    assign frame_end = (state_q == TM_RUN) && (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= TM_HALT;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                TM_HALT: begin
                    if (idx_we)
                        idx_q <= idx_wdata;
                    if (run_req) begin
                        state_q <= TM_RUN;
                        cnt_q   <= '0;
                    end
                end
                TM_RUN: begin
                    if (frame_end) begin
                        cnt_q <= '0;
                        idx_q <= idx_q + 1'b1;
                        if (!run_req)
                            state_q <= TM_HALT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= TM_HALT;
            endcase
        end
    end

    assign running   = (state_q == TM_RUN);
    assign sof       = running && (cnt_q == '0);
    assign frame_idx = idx_q;

endmodule

// File: rtl/usbh_ft_addr.sv
module usbh_ft_addr
    import usbh_ft_pkg::*;
(
    input  logic [BASE_HI_W-1:0] base_hi,
    input  logic [FIDX_W-1:0]    frame_idx,
    input  logic                 sof,
    output logic [ADDR_W-1:0]    entry_addr,
    output logic                 fetch
);

    assign entry_addr = slot_addr(base_hi, frame_idx);
    assign fetch      = sof;

endmodule

// File: rtl/usbh_frame_timer.sv
module usbh_frame_timer
    import usbh_ft_pkg::*;
#(
    parameter int FRAME_BASE = 11936
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         io_addr,
    input  logic               io_we,
    input  logic [15:0]        io_wdata,
    output logic [15:0]        io_rdata,
    input  logic               base_we,
    input  logic [31:0]        base_wdata,
    output logic [31:0]        base_rdata,
    input  logic [4:0]         sts_evt,
    output logic               sof_pulse,
    output logic [10:0]        frame_num,
    output logic [31:0]        fl_entry_addr,
    output logic               fl_fetch
);

    cmd_t                  cmd;
    logic [SOFT_W-1:0]     sof_timing;
    logic [BASE_HI_W-1:0]  base_hi;
    logic                  idx_we;
    logic                  running;
    logic                  halted;
    logic                  run_stop;
    logic                  hc_reset;

    assign halted   = !running;
    assign run_stop = cmd.run;
    assign hc_reset = cmd.hc_reset;

    usbh_ft_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_we      (io_we),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .sts_evt    (sts_evt),
        .halted     (halted),
        .frame_idx  (frame_num),
        .cmd        (cmd),
        .sof_timing (sof_timing),
        .base_hi    (base_hi),
        .idx_we     (idx_we)
    );

    usbh_ft_timer #(
        .FRAME_BASE (FRAME_BASE)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .clr        (hc_reset),
        .run_req    (run_stop),
        .sof_timing (sof_timing),
        .idx_we     (idx_we),
        .idx_wdata  (io_wdata[FIDX_W-1:0]),
        .running    (running),
        .sof        (sof_pulse),
        .frame_idx  (frame_num)
    );

    usbh_ft_addr u_addr (
        .base_hi    (base_hi),
        .frame_idx  (frame_num),
        .sof        (sof_pulse),
        .entry_addr (fl_entry_addr),
        .fetch      (fl_fetch)
    );

    assign base_rdata = {base_hi, {ALIGN_W{1'b0}}};

endmodule

// File: rtl/usbh_frame_timer_chk.sv
module usbh_frame_timer_chk #(
    parameter int FRAME_BASE = 11936
)(
    input logic        clk,
    input logic        rst,
    input logic        sof_pulse,
    input logic        halted,
    input logic        run_stop,
    input logic        hc_reset,
    input logic [6:0]  sof_timing,
    input logic [10:0] frame_num,
    input logic        fl_fetch,
    input logic [31:0] fl_entry_addr,
    input logic [31:0] base_rdata
);

    logic [15:0] gap_cnt;
    logic        have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= '0;
            have_prev <= 1'b0;
        end else begin
            gap_cnt   <= sof_pulse ? 16'd1 : gap_cnt + 16'd1;
            if (halted || hc_reset)
                have_prev <= 1'b0;
            else if (sof_pulse)
                have_prev <= 1'b1;
        end
    end

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        (sof_pulse && have_prev) |-> (gap_cnt == 16'(FRAME_BASE) + 16'($past(sof_timing)))); // R2

    AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |=> !sof_pulse); // R4

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !(sof_pulse || fl_fetch)); // R4

    AST_FRNUM_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$stable(frame_num) && !$past(halted) && !$past(hc_reset))
            |-> (frame_num == 11'($past(frame_num) + 11'd1))); // R5

    AST_SLOT_ADDR: assert property (@(posedge clk) disable iff (rst)
        fl_fetch |-> (fl_entry_addr[31:12] == base_rdata[31:12]
                      && fl_entry_addr[11:2] == frame_num[9:0]
                      && fl_entry_addr[1:0] == 2'b00)); // R6

    AST_RUN_RESUME: assert property (@(posedge clk) disable iff (rst)
        (halted && run_stop && !hc_reset) |=> !halted); // R8

    AST_RESET_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hc_reset |=> (!hc_reset && halted && sof_timing == 7'h40 && frame_num == 11'd0)); // R12

endmodule

bind usbh_frame_timer usbh_frame_timer_chk #(
    .FRAME_BASE (FRAME_BASE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sof_pulse     (sof_pulse),
    .halted        (halted),
    .run_stop      (run_stop),
    .hc_reset      (hc_reset),
    .sof_timing    (sof_timing),
    .frame_num     (frame_num),
    .fl_fetch      (fl_fetch),
    .fl_entry_addr (fl_entry_addr),
    .base_rdata    (base_rdata)
);

// File: tb/usbh_frame_timer_bench.sv
module usbh_frame_timer_bench;

    localparam int HALF_NS  = 10;       // 50 MHz bench clock, in ns
    localparam int WD_LIMIT = 190000;   // cycles
    localparam logic [2:0] A_CMD = 3'd0, A_STS = 3'd1, A_FRN = 3'd2, A_SOF = 3'd3;
    localparam logic [31:0] BASE = 32'h1234_5000;

    typedef struct {
        logic [10:0] idx;
        logic [31:0] addr;
        int          gap;   // 0: first frame of a run, spacing not checked
    } sof_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  io_addr = '0;
    logic        io_we = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic [31:0] base_rdata;
    logic [4:0]  sts_evt = '0;
    logic        sof_pulse;
    logic [10:0] frame_num;
    logic [31:0] fl_entry_addr;
    logic        fl_fetch;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_sof = 0;
    bit done = 1'b0;
    sof_item_t sb[$];

    usbh_frame_timer u_usbh_frame_timer (
        .clk           (clk),
        .rst           (rst),
        .io_addr       (io_addr),
        .io_we         (io_we),
        .io_wdata      (io_wdata),
        .io_rdata      (io_rdata),
        .base_we       (base_we),
        .base_wdata    (base_wdata),
        .base_rdata    (base_rdata),
        .sts_evt       (sts_evt),
        .sof_pulse     (sof_pulse),
        .frame_num     (frame_num),
        .fl_entry_addr (fl_entry_addr),
        .fl_fetch      (fl_fetch)
    );

    always #HALF_NS clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        io_addr = a;
        #1 d = io_rdata;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [15:0] e, input string req);
        logic [15:0] d;
        rd(a, d);
        check(d == e, req, {16'h0, d}, {16'h0, e});
    endtask

    task automatic push(input logic [10:0] idx, input int gap);
        sof_item_t it;
        it.idx  = idx;
        it.addr = {BASE[31:12], idx[9:0], 2'b00};
        it.gap  = gap;
        sb.push_back(it);
    endtask

    task automatic wait_sof(output int at);
        @(negedge clk iff sof_pulse);
        at = cyc;
    endtask

    task automatic wait_halted(output int at);
        logic [15:0] d;
        at = -1;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STS, d);
            if (d[5]) begin
                at = cyc;
                break;
            end
        end
    endtask

    // monitor: pops the scoreboard on every start-of-frame pulse
    always @(negedge clk) begin
        if (!rst && sof_pulse) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4 unexpected start-of-frame", {21'h0, frame_num}, 32'h0);
            end else begin
                sof_item_t it;
                it = sb.pop_front();
                check(frame_num == it.idx, "R5 frame number at SOF", {21'h0, frame_num}, {21'h0, it.idx});
                check(fl_entry_addr == it.addr, "R6 entry address at SOF", fl_entry_addr, it.addr);
                check(fl_fetch, "R4 fetch strobe with SOF", {31'h0, fl_fetch}, 32'h1);
                if (it.gap != 0)
                    check(cyc - last_sof == it.gap, "R2 frame length", cyc - last_sof, it.gap);
            end
            last_sof = cyc;
        end
    end

    initial begin
        int c, t_sof, t_halt;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg(A_CMD, 16'h0000, "R1 command after reset");
        expect_reg(A_STS, 16'h0020, "R1 status after reset");
        expect_reg(A_FRN, 16'h0000, "R1 frame number after reset");
        expect_reg(A_SOF, 16'h0040, "R1 trim after reset");
        check(base_rdata == 32'h0 && !sof_pulse, "R1 base and pulse after reset", base_rdata, 32'h0);

        // R7 base alignment
        @(negedge clk);
        base_wdata = 32'h1234_5ABC; base_we = 1'b1;
        @(negedge clk);
        base_we = 1'b0;
        check(base_rdata == BASE, "R7 base low bits zero", base_rdata, BASE);

        // R5 / R9 frame number while halted
        wr(A_FRN, 16'hFFFF);
        expect_reg(A_FRN, 16'h07FF, "R5 frame number upper bits zero");
        wr(A_FRN, 16'h07FE);
        expect_reg(A_FRN, 16'h07FE, "R9 frame number write while halted");

        // run 1: default trim, crosses both wraps
        push(11'h7FE, 0);
        push(11'h7FF, 12000);
        push(11'h000, 12000);
        wr(A_CMD, 16'h0001);
        c = cyc;
        wait_sof(t_sof);
        check(t_sof == c + 1, "R4 first SOF one cycle after run write", t_sof, c + 1);
        expect_reg(A_STS, 16'h0000, "R8 halted clears on run");
        wr(A_FRN, 16'h0100);
        expect_reg(A_FRN, 16'h07FE, "R9 frame number write ignored while running");
        wait_sof(t_sof);
        wait_sof(t_sof);
        wr(A_CMD, 16'h0000);
        expect_reg(A_STS, 16'h0000, "R8 still running after run bit cleared");
        wait_halted(t_halt);
        check(t_halt - t_sof == 12000, "R8 halt at frame end", t_halt - t_sof, 12000);
        expect_reg(A_FRN, 16'h0001, "R5 frame number wrapped");
        repeat (50) @(negedge clk);
        check(sb.size() == 0, "R8 no SOF after halt", sb.size(), 0);

        // run 2: trim zero
        wr(A_FRN, 16'h0005);
        wr(A_SOF, 16'h0000);
        push(11'h005, 0);
        push(11'h006, 11936);
        wr(A_CMD, 16'h0001);
        wait_sof(t_sof);
        wait_sof(t_sof);
        wr(A_CMD, 16'h0000);
        wait_halted(t_halt);
        check(t_halt - t_sof == 11936, "R2 halt spacing with trim zero", t_halt - t_sof, 11936);

        // run 3: maximum trim
        wr(A_SOF, 16'h01FF);
        expect_reg(A_SOF, 16'h007F, "R3 trim upper bits zero");
        push(11'h007, 0);
        push(11'h008, 12063);
        wr(A_CMD, 16'h0001);
        wait_sof(t_sof);
        wait_sof(t_sof);
        wr(A_CMD, 16'h0000);
        wait_halted(t_halt);
        expect_reg(A_FRN, 16'h0009, "R5 frame number after run 3");

        // R11 command storage
        wr(A_CMD, 16'hFFF8);
        expect_reg(A_CMD, 16'h00F8, "R11 command bits 7:0 stored");
        wr(A_CMD, 16'h0000);

        // R10 status events and write-1-to-clear
        @(negedge clk);
        sts_evt = 5'b10101;
        @(negedge clk);
        sts_evt = 5'b00000;
        expect_reg(A_STS, 16'h0035, "R10 status events set");
        wr(A_STS, 16'h0025);
        expect_reg(A_STS, 16'h0030, "R10 write-1-to-clear, halted kept");

        // R12 controller reset while running
        wr(A_SOF, 16'h0011);
        push(11'h009, 0);
        wr(A_CMD, 16'h0001);
        wait_sof(t_sof);
        wr(A_CMD, 16'h0002);
        io_addr = A_CMD;
        #1 check(io_rdata == 16'h0002, "R12 reset bit visible one cycle", {16'h0, io_rdata}, 32'h2);
        expect_reg(A_CMD, 16'h0000, "R12 reset bit self-clears");
        expect_reg(A_STS, 16'h0020, "R12 status default and halted at once");
        expect_reg(A_SOF, 16'h0040, "R12 trim back to default");
        expect_reg(A_FRN, 16'h0000, "R12 frame number cleared");
        check(base_rdata == 32'h0, "R12 base cleared", base_rdata, 32'h0);
        repeat (12100) @(negedge clk);
        check(sb.size() == 0, "R12 no SOF after controller reset", sb.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule